// File: doc/BRIEF.md
# Peripheral Tick Prescaler

This block turns one oscillator clock into six clock-enable pulse streams: one for each of three timers, one for the timer-2 baud-rate generator, one for the serial port's synchronous shift mode and one for its fixed-rate mode. Each stream is a single-cycle pulse that repeats at a fixed period. The timers and serial shifters sample that pulse as their count enable, so none of them needs a clock of its own.

Each consumer's period comes from a table. Two things index it: whether the core runs at full speed or in the divided low-power mode, and that consumer's own selection bits. In low-power mode a 2-bit divider code sets the machine-cycle length M. Every low-power period is a small multiple of M. Each stream has its own counter. When a selection or the power mode changes a stream's period, that counter restarts, so the first pulse after the change comes one whole new period later.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and there is no back-pressure.

Top module: `tick_prescaler`

## Requirements
- R1: While reset is asserted every tick output is low. After reset all three timers with selection 00 at full speed tick every 12 oscillator clocks.
- R2: At full speed a timer with selection 00 ticks every 12 clocks, with 01 every 4 clocks, and with 10 or 11 on every clock.
- R3: In low-power mode the machine-cycle length M is 4, 64, 256 or 1024 clocks for divider codes 00, 01, 10 and 11.
- R4: In low-power mode a timer with selection 00 ticks every 3M clocks. Any other selection gives a tick every M clocks.
- R5: The baud-rate tick period is 2 clocks at full speed and 2M clocks in low-power mode. The timer-2 selection bits have no effect on it.
- R6: The serial shift-mode tick period is 12 clocks (speed bit 0) or 4 clocks (speed bit 1) at full speed. In low-power mode it is 3M or M.
- R7: The serial fixed-rate tick period is 64 clocks (doubling bit 0) or 32 clocks (doubling bit 1) at full speed. In low-power mode it is 16M or 8M.
- R8: Each tick output is high for exactly one clock per period, and successive rising pulses are exactly one period apart. A period of 1 keeps the output high every clock.
- R9: When a stream's period changes, its output is low after the clock edge that first samples the new settings. Its first pulse follows exactly one new period after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_en | input | 1 | 1 selects the divided low-power mode |
| lp_div | input | 2 | Low-power divider code (R3) |
| tmr_sel0 | input | 2 | Timer 0 speed selection |
| tmr_sel1 | input | 2 | Timer 1 speed selection |
| tmr_sel2 | input | 2 | Timer 2 speed selection |
| ser0_fast | input | 1 | Serial shift-mode speed bit |
| ser2_dbl | input | 1 | Serial fixed-rate doubling bit |
| tick_tmr0 | output | 1 | Timer 0 enable pulse |
| tick_tmr1 | output | 1 | Timer 1 enable pulse |
| tick_tmr2 | output | 1 | Timer 2 enable pulse |
| tick_baud | output | 1 | Baud-rate generator enable pulse |
| tick_ser0 | output | 1 | Serial shift-mode enable pulse |
| tick_ser2 | output | 1 | Serial fixed-rate enable pulse |

## Verification
The assertions assume that the selection and mode inputs change only between clock edges and are otherwise free to change at any time. A pulse cut short by a change is covered by the restart rule rather than by the single-pulse rule. The stimulus drives every setting on the falling edge and then holds it for at least two full periods of the slowest affected stream. This lets each stream show both its restart distance and a steady pulse-to-pulse interval. Each new setting changes the period of most streams. Streams whose period does not change are checked only on their interval, because their phase carries over from before.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    CH_TMR  = 2'd0,
    CH_BAUD = 2'd1,
    CH_SER0 = 2'd2,
    CH_SER2 = 2'd3
  } chan_kind_e;

  localparam int unsigned SH_W   = 5;
  localparam int unsigned NUM_TMR = 3;
  localparam int unsigned NUM_CH  = NUM_TMR + 3;

  function automatic chan_kind_e kind_of(input int idx);
    if (idx < int'(NUM_TMR))           return CH_TMR;
    else if (idx == int'(NUM_TMR))     return CH_BAUD;
    else if (idx == int'(NUM_TMR) + 1) return CH_SER0;
    else                               return CH_SER2;
  endfunction

endpackage

// File: rtl/tick_mc_decode.sv
module tick_mc_decode
  import tick_pkg::*;
#(
  parameter int unsigned LP_SH0 = 2,
  parameter int unsigned LP_SH1 = 6,
  parameter int unsigned LP_SH2 = 8,
  parameter int unsigned LP_SH3 = 10
) (
  input  logic [1:0]      lp_div,
  output logic [SH_W-1:0] mc_shift
);

  always_comb begin
    unique case (lp_div)
      2'b00:   mc_shift = SH_W'(LP_SH0);
      2'b01:   mc_shift = SH_W'(LP_SH1);
      2'b10:   mc_shift = SH_W'(LP_SH2);
      default: mc_shift = SH_W'(LP_SH3);
    endcase
  end

endmodule

// File: rtl/tick_rate_select.sv
module tick_rate_select
  import tick_pkg::*;
#(
  parameter chan_kind_e KIND    = CH_TMR,
  parameter int unsigned PER_W  = 15,
  parameter int unsigned LP_MIN = 4,
  parameter int unsigned FS_TMR_LEGACY = 12,
  parameter int unsigned FS_TMR_QUAD   = 4,
  parameter int unsigned FS_BAUD       = 2,
  parameter int unsigned FS_SER0_SLOW  = 12,
  parameter int unsigned FS_SER0_FAST  = 4,
  parameter int unsigned FS_SER2_SLOW  = 64,
  parameter int unsigned FS_SER2_FAST  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_en,
  input  logic [SH_W-1:0]  mc_shift,
  input  logic [1:0]       sel,
  output logic [PER_W-1:0] period
);

  logic [PER_W-1:0] fs_per;
  logic [PER_W-1:0] lp_mult;

  generate
    if (KIND == CH_TMR) begin : g_tmr
      always_comb begin
        unique case (sel)
          2'b00:   fs_per = PER_W'(FS_TMR_LEGACY);
          2'b01:   fs_per = PER_W'(FS_TMR_QUAD);
          default: fs_per = PER_W'(1);
        endcase
        lp_mult = (sel == 2'b00) ? PER_W'(3) : PER_W'(1);
      end
    end else if (KIND == CH_BAUD) begin : g_baud
      always_comb begin
        fs_per  = PER_W'(FS_BAUD);
        lp_mult = PER_W'(2);
      end
    end else if (KIND == CH_SER0) begin : g_ser0
      always_comb begin
        fs_per  = sel[0] ? PER_W'(FS_SER0_FAST) : PER_W'(FS_SER0_SLOW);
        lp_mult = sel[0] ? PER_W'(1) : PER_W'(3);
      end
    end else begin : g_ser2
      always_comb begin
        fs_per  = sel[0] ? PER_W'(FS_SER2_FAST) : PER_W'(FS_SER2_SLOW);
        lp_mult = sel[0] ? PER_W'(8) : PER_W'(16);
      end
    end
  endgenerate

  assign period = lp_en ? (lp_mult << mc_shift) : fs_per;

  // Low-power periods never fall below the shortest machine cycle.
  assert_lp_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lp_en |-> (period >= PER_W'(LP_MIN)));

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned PER_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);

  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cnt_q;
  logic             reload;
  logic             wrap;

  assign reload = (period_i != per_q);
  assign wrap   = (cnt_q == per_q - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (reload) begin
      per_q  <= period_i;
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + PER_W'(1);
      tick_o <= 1'b0;
    end
  end

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && per_q > PER_W'(1)) |=> !tick_o);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) |-> (cnt_q < per_q));

  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i != per_q) |=> (!tick_o && cnt_q == '0));

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_pkg::*;
#(
  parameter int unsigned LP_SH0 = 2,
  parameter int unsigned LP_SH1 = 6,
  parameter int unsigned LP_SH2 = 8,
  parameter int unsigned LP_SH3 = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_en,
  input  logic [1:0] lp_div,
  input  logic [1:0] tmr_sel0,
  input  logic [1:0] tmr_sel1,
  input  logic [1:0] tmr_sel2,
  input  logic       ser0_fast,
  input  logic       ser2_dbl,
  output logic       tick_tmr0,
  output logic       tick_tmr1,
  output logic       tick_tmr2,
  output logic       tick_baud,
  output logic       tick_ser0,
  output logic       tick_ser2
);

  localparam int unsigned MAX_PER = 16 << LP_SH3;
  localparam int unsigned PER_W   = $clog2(MAX_PER + 1);
  localparam int unsigned LP_MIN  = 1 << LP_SH0;

  logic [SH_W-1:0]  mc_shift;
  logic [1:0]       sel_arr    [NUM_CH];
  logic [PER_W-1:0] period_arr [NUM_CH];
  logic [NUM_CH-1:0] tick_vec;

  tick_mc_decode #(
    .LP_SH0(LP_SH0), .LP_SH1(LP_SH1), .LP_SH2(LP_SH2), .LP_SH3(LP_SH3)
  ) u_mc (
    .lp_div  (lp_div),
    .mc_shift(mc_shift)
  );

  always_comb begin
    sel_arr[0] = tmr_sel0;
    sel_arr[1] = tmr_sel1;
    sel_arr[2] = tmr_sel2;
    sel_arr[3] = tmr_sel2;
    sel_arr[4] = {1'b0, ser0_fast};
    sel_arr[5] = {1'b0, ser2_dbl};
  end

  generate
    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
      localparam chan_kind_e K = kind_of(i);

      tick_rate_select #(
        .KIND  (K),
        .PER_W (PER_W),
        .LP_MIN(LP_MIN)
      ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .lp_en   (lp_en),
        .mc_shift(mc_shift),
        .sel     (sel_arr[i]),
        .period  (period_arr[i])
      );

      tick_divider #(
        .PER_W(PER_W)
      ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .period_i(period_arr[i]),
        .tick_o  (tick_vec[i])
      );
    end
  endgenerate

  assign tick_tmr0 = tick_vec[0];
  assign tick_tmr1 = tick_vec[1];
  assign tick_tmr2 = tick_vec[2];
  assign tick_baud = tick_vec[3];
  assign tick_ser0 = tick_vec[4];
  assign tick_ser2 = tick_vec[5];

  // The baud period must not follow the timer-2 selection bits.
  assert_baud_sel_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tmr_sel2) && $stable(lp_en) && $stable(lp_div))
      |-> $stable(period_arr[3]));

endmodule

// File: tb/tb_tick_prescaler.sv
module tb_tick_prescaler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lp_en = 1'b0;
  logic [1:0] lp_div = 2'b00;
  logic [1:0] tmr_sel0 = 2'b00, tmr_sel1 = 2'b00, tmr_sel2 = 2'b00;
  logic       ser0_fast = 1'b0, ser2_dbl = 1'b0;
  logic       tick_tmr0, tick_tmr1, tick_tmr2, tick_baud, tick_ser0, tick_ser2;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int    per [6];
    bit    chg [6];
    string tag [6];
  } exp_t;

  exp_t scb_q[$];
  int   prev_per [6];

  always #2 clk = ~clk;

  tick_prescaler dut (
    .clk(clk), .rst_n(rst_n), .lp_en(lp_en), .lp_div(lp_div),
    .tmr_sel0(tmr_sel0), .tmr_sel1(tmr_sel1), .tmr_sel2(tmr_sel2),
    .ser0_fast(ser0_fast), .ser2_dbl(ser2_dbl),
    .tick_tmr0(tick_tmr0), .tick_tmr1(tick_tmr1), .tick_tmr2(tick_tmr2),
    .tick_baud(tick_baud), .tick_ser0(tick_ser0), .tick_ser2(tick_ser2)
  );

  function automatic logic [5:0] ticks();
    return {tick_ser2, tick_ser0, tick_baud, tick_tmr2, tick_tmr1, tick_tmr0};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected periods written from the requirement table (R2..R7).
  function automatic int mcyc(input int code);
    case (code)
      0: return 4;
      1: return 64;
      2: return 256;
      default: return 1024;
    endcase
  endfunction

  function automatic int exp_per(input int ch, input bit lp, input int code,
                                 input int sel, input bit bitv);
    int m = mcyc(code);
    case (ch)
      0, 1, 2: return lp ? ((sel == 0) ? 3 * m : m)
                         : ((sel == 0) ? 12 : (sel == 1) ? 4 : 1);
      3:       return lp ? 2 * m : 2;
      4:       return lp ? (bitv ? m : 3 * m) : (bitv ? 4 : 12);
      default: return lp ? (bitv ? 8 * m : 16 * m) : (bitv ? 32 : 64);
    endcase
  endfunction

  // Driver: applies settings and pushes the expected periods.
  task automatic drive(input bit lp, input int code, input int s0, input int s1,
                       input int s2, input bit f0, input bit d2);
    exp_t e;
    lp_en = lp; lp_div = 2'(code);
    tmr_sel0 = 2'(s0); tmr_sel1 = 2'(s1); tmr_sel2 = 2'(s2);
    ser0_fast = f0; ser2_dbl = d2;
    e.per[0] = exp_per(0, lp, code, s0, 1'b0);
    e.per[1] = exp_per(1, lp, code, s1, 1'b0);
    e.per[2] = exp_per(2, lp, code, s2, 1'b0);
    e.per[3] = exp_per(3, lp, code, s2, 1'b0);
    e.per[4] = exp_per(4, lp, code, 0, f0);
    e.per[5] = exp_per(5, lp, code, 0, d2);
    for (int c = 0; c < 6; c++) begin
      e.chg[c] = (e.per[c] != prev_per[c]);
      prev_per[c] = e.per[c];
    end
    e.tag[0] = lp ? "R3 R4 tmr0" : "R2 tmr0";
    e.tag[1] = lp ? "R3 R4 tmr1" : "R2 tmr1";
    e.tag[2] = lp ? "R3 R4 tmr2" : "R2 tmr2";
    e.tag[3] = "R5 baud";
    e.tag[4] = "R6 ser0";
    e.tag[5] = "R7 ser2";
    scb_q.push_back(e);
  endtask

  // Monitor: pops one expectation and measures the six pulse streams.
  task automatic monitor();
    exp_t e;
    int   first [6];
    int   second [6];
    int   maxp = 1;
    logic [5:0] t, tp;
    e = scb_q.pop_front();
    for (int c = 0; c < 6; c++) begin
      first[c] = 0; second[c] = 0;
      if (e.per[c] > maxp) maxp = e.per[c];
    end
    tp = '0;
    for (int k = 1; k <= 2 * maxp + 4; k++) begin
      @(negedge clk);
      t = ticks();
      for (int c = 0; c < 6; c++) begin
        if (k == 1 && e.chg[c])
          check(!t[c], "R9", {e.tag[c], " low after restart edge"}, int'(t[c]), 0);
        if (t[c] && tp[c] && e.per[c] > 1 && k > 1)
          check(1'b0, "R8", {e.tag[c], " pulse wider than one clock"}, 2, 1);
        if (t[c]) begin
          if (first[c] == 0) first[c] = k;
          else if (second[c] == 0) second[c] = k;
        end
      end
      tp = t;
    end
    for (int c = 0; c < 6; c++) begin
      check(second[c] - first[c] == e.per[c], "R8",
            {e.tag[c], " pulse interval"}, second[c] - first[c], e.per[c]);
      if (e.chg[c])
        check(first[c] == e.per[c] + 1, "R9",
              {e.tag[c], " first pulse after change"}, first[c], e.per[c] + 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 6; c++) prev_per[c] = 0;
    // R1: reset state and default legacy timer rate.
    drive(1'b0, 0, 0, 1, 2, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    check(ticks() == 6'b0, "R1", "ticks low in reset", int'(ticks()), 0);
    @(negedge clk);
    rst_n = 1'b1;
    monitor();   // R1 timer0 sel 00 -> 12, R2 R5 R6 R7 full speed slow settings
    drive(1'b0, 0, 3, 0, 1, 1'b1, 1'b1);   // R2 R6 R7 fast settings
    monitor();
    drive(1'b1, 0, 0, 1, 3, 1'b0, 1'b0);   // R3 code 00
    monitor();
    drive(1'b1, 1, 0, 2, 1, 1'b1, 1'b1);   // R3 code 01
    monitor();
    drive(1'b1, 2, 1, 0, 0, 1'b0, 1'b0);   // R3 code 10
    monitor();
    drive(1'b1, 3, 0, 1, 2, 1'b0, 1'b1);   // R3 code 11
    monitor();
    drive(1'b1, 3, 0, 1, 0, 1'b1, 1'b0);   // R5 timer-2 selection ignored
    monitor();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule